// File: doc/BRIEF.md
# Dual-Thread Shared Stack Cache

This block keeps the top portions of two hardware threads' operand stacks in one shared register array. The array holds `DEPTH` words. Thread 0 owns the lower half, starting at entry 0, and thread 1 owns the upper half, starting at entry `DEPTH/2`. Each thread keeps a ring inside its half: a bottom pointer marks its oldest cached word and a count gives its depth, so its top of stack is the bottom pointer plus the count, taken modulo `DEPTH/2`. Each thread has its own request port, and it can push, pop or peek at a word a given distance below its top. Both ports act in the same cycle, and because the two halves are disjoint they never touch the same entry.

The total occupancy of the array is compared against two thresholds, `HI_MARK` and `LO_MARK`. A dribble controller moves words to and from a backing memory port one word per cycle. Spills write a thread's oldest word out to memory. Fills bring the most recently spilled word back in below that thread's oldest word. Two further conditions start a dribble: a thread whose half is full is spilled, and a thread that is empty but has spilled words is filled. While a word moves, `stall` is high and both ports' requests are dropped.

The backing memory is addressed as `{thread, index}`, where index counts that thread's words held in memory. Read data is expected in the same cycle as the read.

Top module: `sc_dual_stack`

## Requirements
- R1: While reset is high and in the first cycle after it, `stall`, `mem_we`, `mem_re`, `p0_rvalid` and `p1_rvalid` are all 0, and both threads are empty.
- R2: Op code 1 (push) stores the write data as the new top of that port's thread. Op code 2 (pop) removes the top, returning it on rdata with rvalid high in the next cycle, in last-in first-out order. Op code 0 does nothing, and its rvalid is 0.
- R3: Op code 3 (peek) with offset k returns the word k places below the top, with k = 0 meaning the top, without changing the stack. A peek with k greater than or equal to the thread's count is ignored and gives rvalid 0.
- R4: A pop on an empty thread that has no spilled words is ignored and gives rvalid 0.
- R5: The two ports work in the same cycle without affecting each other, and neither thread ever reads the other's words.
- R6: When a thread holds `DEPTH/2` words, the next cycle stalls and spills that thread's oldest word. This overflow rule has the highest priority, and thread 0 is served first.
- R7: When the combined count exceeds `HI_MARK`, one word is spilled per cycle from the thread holding more words, with thread 0 chosen on a tie, until the combined count is at most `HI_MARK`.
- R8: When the combined count is below `LO_MARK` and spilled words exist, one word is filled per cycle. The thread chosen has spilled words and holds fewer words, with thread 0 chosen on a tie. The word restored is the last one that thread spilled, and it goes in below the thread's oldest word.
- R9: A thread with no cached words but with spilled words is filled before any watermark action. Only the overflow spill of R6 comes before it.
- R10: Every stall cycle moves exactly one word (exactly one of `mem_we`, `mem_re` is high). Port requests made in a stall cycle are ignored and give rvalid 0 in the next cycle. Outside a stall, both memory strobes stay low.
- R11: The memory address is `{thread, n}` with the thread in the most significant bit. A spill uses n equal to the number of words the thread already holds in memory. A fill uses that number minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_op | input | 2 | Thread 0 request: 0 none, 1 push, 2 pop, 3 peek |
| p0_off | input | AW | Thread 0 peek distance below the top |
| p0_wdata | input | WIDTH | Thread 0 push data |
| p0_rdata | output | WIDTH | Thread 0 pop/peek result (registered) |
| p0_rvalid | output | 1 | Thread 0 result valid |
| p1_op | input | 2 | Thread 1 request, same coding |
| p1_off | input | AW | Thread 1 peek distance below the top |
| p1_wdata | input | WIDTH | Thread 1 push data |
| p1_rdata | output | WIDTH | Thread 1 pop/peek result (registered) |
| p1_rvalid | output | 1 | Thread 1 result valid |
| stall | output | 1 | A dribble word moves this cycle; requests are dropped |
| mem_we | output | 1 | Spill write strobe |
| mem_re | output | 1 | Fill read strobe |
| mem_addr | output | MEM_AW | Backing address `{thread, index}` |
| mem_wdata | output | WIDTH | Spilled word |
| mem_rdata | input | WIDTH | Filled word, valid in the same cycle |

## Verification
The bench builds the block with `DEPTH` = 8, `HI_MARK` = 4, `LO_MARK` = 2, `WIDTH` = 16 and `MEM_AW` = 6. With these values a half-array overflow is only four pushes away. They also make the two-thread case reachable where the combined count exceeds the high mark while neither thread is full, both with one thread larger and with a tie. Because the low mark is this small, draining both threads exposes the empty-thread fill order and the exact spill and fill addresses within a few dozen cycles.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_PEEK = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        DR_NONE  = 2'd0,
        DR_SPILL = 2'd1,
        DR_FILL  = 2'd2
    } dr_kind_e;

    typedef struct packed {
        dr_kind_e kind;
        logic     thr;
    } dr_cmd_t;

endpackage

// File: rtl/sc_thread_ptr.sv
module sc_thread_ptr
    import sc_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MEM_AW = 10,
    parameter int THR    = 0,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW - 1,
    localparam int SPW   = MEM_AW - 1
) (
    input  logic           clk,
    input  logic           rst,
    input  stk_op_e        op,
    input  logic [AW-1:0]  off,
    input  logic           stall,
    input  logic           spill_go,
    input  logic           fill_go,
    output logic [AW-1:0]  cnt,
    output logic [SPW-1:0] sp,
    output logic           wr_en,
    output logic [AW-1:0]  wr_idx,
    output logic           rd_en,
    output logic [AW-1:0]  rd_idx,
    output logic [AW-1:0]  dr_idx
);
    localparam int HALF = DEPTH / 2;

    logic [LW-1:0]  bot_q;
    logic [AW-1:0]  cnt_q;
    logic [SPW-1:0] sp_q;
    logic [LW-1:0]  top_l;
    logic [LW-1:0]  rd_l;
    logic           th;
    logic           push_ok, pop_ok, peek_ok;

    assign th      = (THR != 0);
    assign top_l   = bot_q + cnt_q[LW-1:0];
    assign rd_l    = top_l - LW'(1) - ((op == OP_PEEK) ? off[LW-1:0] : '0);

    assign push_ok = !stall && (op == OP_PUSH) && (cnt_q < AW'(HALF));
    assign pop_ok  = !stall && (op == OP_POP)  && (cnt_q != '0);
    assign peek_ok = !stall && (op == OP_PEEK) && (off < cnt_q);

    assign wr_en   = push_ok;
    assign wr_idx  = {th, top_l};
    assign rd_en   = pop_ok || peek_ok;
    assign rd_idx  = {th, rd_l};
    assign dr_idx  = {th, fill_go ? (bot_q - LW'(1)) : bot_q};

    assign cnt     = cnt_q;
    assign sp      = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bot_q <= '0;
            cnt_q <= '0;
            sp_q  <= '0;
        end else if (spill_go) begin
            bot_q <= bot_q + LW'(1);
            cnt_q <= cnt_q - AW'(1);
            sp_q  <= sp_q + SPW'(1);
        end else if (fill_go) begin
            bot_q <= bot_q - LW'(1);
            cnt_q <= cnt_q + AW'(1);
            sp_q  <= sp_q - SPW'(1);
        end else if (push_ok) begin
            cnt_q <= cnt_q + AW'(1);
        end else if (pop_ok) begin
            cnt_q <= cnt_q - AW'(1);
        end
    end

endmodule

// File: rtl/sc_dribble_ctl.sv
module sc_dribble_ctl
    import sc_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int MEM_AW  = 10,
    parameter int HI_MARK = 48,
    parameter int LO_MARK = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int SPW    = MEM_AW - 1
) (
    input  logic [AW-1:0]  cnt0,
    input  logic [AW-1:0]  cnt1,
    input  logic [SPW-1:0] sp0,
    input  logic [SPW-1:0] sp1,
    output dr_cmd_t        cmd
);
    localparam int HALF = DEPTH / 2;

    logic [AW:0] occ;
    logic        full0, full1, starve0, starve1;

    assign occ     = {1'b0, cnt0} + {1'b0, cnt1};
    assign full0   = (cnt0 == AW'(HALF));
    assign full1   = (cnt1 == AW'(HALF));
    assign starve0 = (cnt0 == '0) && (sp0 != '0);
    assign starve1 = (cnt1 == '0) && (sp1 != '0);

    always_comb begin
        cmd = '{kind: DR_NONE, thr: 1'b0};
        if (full0) begin
            cmd = '{kind: DR_SPILL, thr: 1'b0};
        end else if (full1) begin
            cmd = '{kind: DR_SPILL, thr: 1'b1};
        end else if (starve0) begin
            cmd = '{kind: DR_FILL, thr: 1'b0};
        end else if (starve1) begin
            cmd = '{kind: DR_FILL, thr: 1'b1};
        end else if (occ > (AW+1)'(HI_MARK)) begin
            cmd = '{kind: DR_SPILL, thr: (cnt1 > cnt0)};
        end else if (occ < (AW+1)'(LO_MARK)) begin
            if ((sp0 != '0) && ((sp1 == '0) || (cnt0 <= cnt1))) begin
                cmd = '{kind: DR_FILL, thr: 1'b0};
            end else if (sp1 != '0) begin
                cmd = '{kind: DR_FILL, thr: 1'b1};
            end
        end
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we0,
    input  logic [AW-1:0]    wa0,
    input  logic [WIDTH-1:0] wd0,
    input  logic             we1,
    input  logic [AW-1:0]    wa1,
    input  logic [WIDTH-1:0] wd1,
    input  logic             wef,
    input  logic [AW-1:0]    waf,
    input  logic [WIDTH-1:0] wdf,
    input  logic [AW-1:0]    ra0,
    output logic [WIDTH-1:0] rd0,
    input  logic [AW-1:0]    ra1,
    output logic [WIDTH-1:0] rd1,
    input  logic [AW-1:0]    raf,
    output logic [WIDTH-1:0] rdf
);
    logic [WIDTH-1:0] ent_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wef && (waf == AW'(i))) begin
                ent_q[i] <= wdf;
            end else if (we0 && (wa0 == AW'(i))) begin
                ent_q[i] <= wd0;
            end else if (we1 && (wa1 == AW'(i))) begin
                ent_q[i] <= wd1;
            end
        end
    end

    assign rd0 = ent_q[ra0];
    assign rd1 = ent_q[ra1];
    assign rdf = ent_q[raf];

endmodule

// File: rtl/sc_dual_stack.sv
module sc_dual_stack
    import sc_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int WIDTH   = 32,
    parameter int HI_MARK = 48,
    parameter int LO_MARK = 16,
    parameter int MEM_AW  = 10,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        p0_op,
    input  logic [AW-1:0]     p0_off,
    input  logic [WIDTH-1:0]  p0_wdata,
    output logic [WIDTH-1:0]  p0_rdata,
    output logic              p0_rvalid,
    input  logic [1:0]        p1_op,
    input  logic [AW-1:0]     p1_off,
    input  logic [WIDTH-1:0]  p1_wdata,
    output logic [WIDTH-1:0]  p1_rdata,
    output logic              p1_rvalid,
    output logic              stall,
    output logic              mem_we,
    output logic              mem_re,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [WIDTH-1:0]  mem_wdata,
    input  logic [WIDTH-1:0]  mem_rdata
);
    localparam int SPW = MEM_AW - 1;

    stk_op_e          op_in   [2];
    logic [AW-1:0]    off_in  [2];
    logic [WIDTH-1:0] wd_in   [2];
    logic [AW-1:0]    cnt     [2];
    logic [SPW-1:0]   sp      [2];
    logic             wr_en   [2];
    logic [AW-1:0]    wr_idx  [2];
    logic             rd_en   [2];
    logic [AW-1:0]    rd_idx  [2];
    logic [AW-1:0]    dr_idx  [2];
    logic [WIDTH-1:0] rdat    [2];
    logic [WIDTH-1:0] rdata_q [2];
    logic             rvld_q  [2];

    dr_cmd_t          cmd;
    logic [AW-1:0]    dr_sel;
    logic [SPW-1:0]   sp_sel;
    logic             fill_act;

    assign op_in[0]  = stk_op_e'(p0_op);
    assign op_in[1]  = stk_op_e'(p1_op);
    assign off_in[0] = p0_off;
    assign off_in[1] = p1_off;
    assign wd_in[0]  = p0_wdata;
    assign wd_in[1]  = p1_wdata;

    sc_dribble_ctl #(
        .DEPTH(DEPTH), .MEM_AW(MEM_AW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
    ) u_ctl (
        .cnt0(cnt[0]), .cnt1(cnt[1]), .sp0(sp[0]), .sp1(sp[1]), .cmd(cmd)
    );

    assign stall    = (cmd.kind != DR_NONE);
    assign fill_act = (cmd.kind == DR_FILL);
    assign mem_we   = (cmd.kind == DR_SPILL);
    assign mem_re   = fill_act;
    assign dr_sel   = dr_idx[cmd.thr];
    assign sp_sel   = sp[cmd.thr];
    assign mem_addr = {cmd.thr, fill_act ? (sp_sel - SPW'(1)) : sp_sel};

    for (genvar t = 0; t < 2; t++) begin : g_thr
        logic spill_go, fill_go;

        assign spill_go = (cmd.kind == DR_SPILL) && (cmd.thr == 1'(t));
        assign fill_go  = (cmd.kind == DR_FILL)  && (cmd.thr == 1'(t));

        sc_thread_ptr #(
            .DEPTH(DEPTH), .MEM_AW(MEM_AW), .THR(t)
        ) u_ptr (
            .clk(clk), .rst(rst), .op(op_in[t]), .off(off_in[t]),
            .stall(stall), .spill_go(spill_go), .fill_go(fill_go),
            .cnt(cnt[t]), .sp(sp[t]),
            .wr_en(wr_en[t]), .wr_idx(wr_idx[t]),
            .rd_en(rd_en[t]), .rd_idx(rd_idx[t]), .dr_idx(dr_idx[t])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                rvld_q[t]  <= 1'b0;
                rdata_q[t] <= '0;
            end else begin
                rvld_q[t] <= rd_en[t];
                if (rd_en[t]) begin
                    rdata_q[t] <= rdat[t];
                end
            end
        end
    end

    sc_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rf (
        .clk(clk),
        .we0(wr_en[0]), .wa0(wr_idx[0]), .wd0(wd_in[0]),
        .we1(wr_en[1]), .wa1(wr_idx[1]), .wd1(wd_in[1]),
        .wef(fill_act), .waf(dr_sel), .wdf(mem_rdata),
        .ra0(rd_idx[0]), .rd0(rdat[0]),
        .ra1(rd_idx[1]), .rd1(rdat[1]),
        .raf(dr_sel), .rdf(mem_wdata)
    );

    assign p0_rdata  = rdata_q[0];
    assign p0_rvalid = rvld_q[0];
    assign p1_rdata  = rdata_q[1];
    assign p1_rvalid = rvld_q[1];

endmodule

// File: rtl/sc_dual_stack_chk.sv
module sc_dual_stack_chk #(
    parameter int DEPTH   = 64,
    parameter int HI_MARK = 48,
    parameter int MEM_AW  = 10,
    localparam int AW     = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              mem_we,
    input logic              mem_re,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              p0_rvalid,
    input logic              p1_rvalid,
    input logic [AW-1:0]     cnt0,
    input logic [AW-1:0]     cnt1,
    input logic [MEM_AW-2:0] sp0
);
    localparam int HALF = DEPTH / 2;

    logic [AW:0] occ;
    assign occ = {1'b0, cnt0} + {1'b0, cnt1};

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!p0_rvalid && !p1_rvalid && !stall)); // R1

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt0 <= AW'(HALF)) && (cnt1 <= AW'(HALF))); // R6

    AST_FULL_SPILL: assert property (@(posedge clk) disable iff (rst)
        (cnt0 == AW'(HALF)) |-> (stall && mem_we && !mem_addr[MEM_AW-1])); // R6

    AST_HIGH_SPILL: assert property (@(posedge clk) disable iff (rst)
        (occ > (AW+1)'(HI_MARK)) |-> (stall && mem_we)); // R7

    AST_STARVE_FILL: assert property (@(posedge clk) disable iff (rst)
        ((cnt0 == '0) && (sp0 != '0) && (cnt1 != AW'(HALF)))
            |-> (stall && mem_re && !mem_addr[MEM_AW-1])); // R9

    AST_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        stall |-> (mem_we != mem_re)); // R10

    AST_IDLE_MEM: assert property (@(posedge clk) disable iff (rst)
        !stall |-> (!mem_we && !mem_re)); // R10

    AST_STALL_DROP: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!p0_rvalid && !p1_rvalid)); // R10

endmodule

bind sc_dual_stack sc_dual_stack_chk #(
    .DEPTH(DEPTH), .HI_MARK(HI_MARK), .MEM_AW(MEM_AW)
) u_chk (
    .clk(clk), .rst(rst), .stall(stall), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .p0_rvalid(p0_rvalid), .p1_rvalid(p1_rvalid),
    .cnt0(cnt[0]), .cnt1(cnt[1]), .sp0(sp[0])
);

// File: tb/sim_sc_dual_stack.sv
module sim_sc_dual_stack;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 8;
    localparam int WIDTH  = 16;
    localparam int HI     = 4;
    localparam int LO     = 2;
    localparam int MAW    = 6;
    localparam int AW     = $clog2(DEPTH);

    localparam logic [1:0] NOP = 2'd0, PSH = 2'd1, POP = 2'd2, PEK = 2'd3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       p0_op = NOP, p1_op = NOP;
    logic [AW-1:0]    p0_off = '0, p1_off = '0;
    logic [WIDTH-1:0] p0_wdata = '0, p1_wdata = '0;
    logic [WIDTH-1:0] p0_rdata, p1_rdata;
    logic             p0_rvalid, p1_rvalid;
    logic             stall, mem_we, mem_re;
    logic [MAW-1:0]   mem_addr;
    logic [WIDTH-1:0] mem_wdata, mem_rdata;
    logic [WIDTH-1:0] bmem [1 << MAW];

    int errs = 0;
    int checks = 0;

    sc_dual_stack #(
        .DEPTH(DEPTH), .WIDTH(WIDTH), .HI_MARK(HI), .LO_MARK(LO), .MEM_AW(MAW)
    ) u0 (
        .clk(clk), .rst(rst),
        .p0_op(p0_op), .p0_off(p0_off), .p0_wdata(p0_wdata),
        .p0_rdata(p0_rdata), .p0_rvalid(p0_rvalid),
        .p1_op(p1_op), .p1_off(p1_off), .p1_wdata(p1_wdata),
        .p1_rdata(p1_rdata), .p1_rvalid(p1_rvalid),
        .stall(stall), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = bmem[mem_addr];
    always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

    always #(CLK_NS / 2) clk = ~clk;

    typedef struct packed {
        logic [1:0]       op0;
        logic [WIDTH-1:0] w0;
        logic [AW-1:0]    k0;
        logic [1:0]       op1;
        logic [WIDTH-1:0] w1;
        logic [AW-1:0]    k1;
        logic             v0;
        logic [WIDTH-1:0] d0;
        logic             v1;
        logic [WIDTH-1:0] d1;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{PSH, 16'h1111, 3'd0, PSH, 16'h2222, 3'd0, 1'b0, 16'h0,    1'b0, 16'h0},
        '{PSH, 16'h1112, 3'd0, NOP, 16'h0,    3'd0, 1'b0, 16'h0,    1'b0, 16'h0},
        '{PEK, 16'h0,    3'd0, PSH, 16'h2223, 3'd0, 1'b1, 16'h1112, 1'b0, 16'h0},
        '{PEK, 16'h0,    3'd1, PEK, 16'h0,    3'd1, 1'b1, 16'h1111, 1'b1, 16'h2222},
        '{PEK, 16'h0,    3'd2, POP, 16'h0,    3'd0, 1'b0, 16'h0,    1'b1, 16'h2223},
        '{POP, 16'h0,    3'd0, POP, 16'h0,    3'd0, 1'b1, 16'h1112, 1'b1, 16'h2222},
        '{POP, 16'h0,    3'd0, POP, 16'h0,    3'd0, 1'b1, 16'h1111, 1'b0, 16'h0},
        '{POP, 16'h0,    3'd0, NOP, 16'h0,    3'd0, 1'b0, 16'h0,    1'b0, 16'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] o0, input logic [WIDTH-1:0] w0, input logic [AW-1:0] k0,
                         input logic [1:0] o1, input logic [WIDTH-1:0] w1, input logic [AW-1:0] k1);
        p0_op = o0; p0_wdata = w0; p0_off = k0;
        p1_op = o1; p1_wdata = w1; p1_off = k1;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_spill(input string tag, input logic [MAW-1:0] a, input logic [WIDTH-1:0] d);
        check({tag, " stall"}, 32'(stall), 32'd1);
        check({tag, " mem_we"}, 32'(mem_we), 32'd1);
        check({tag, " addr"}, 32'(mem_addr), 32'(a));
        check({tag, " wdata"}, 32'(mem_wdata), 32'(d));
    endtask

    task automatic expect_fill(input string tag, input logic [MAW-1:0] a);
        check({tag, " stall"}, 32'(stall), 32'd1);
        check({tag, " mem_re"}, 32'(mem_re), 32'd1);
        check({tag, " addr"}, 32'(mem_addr), 32'(a));
    endtask

    task automatic expect_rd(input string tag, input logic v0, input logic [WIDTH-1:0] d0,
                             input logic v1, input logic [WIDTH-1:0] d1);
        check({tag, " v0"}, 32'(p0_rvalid), 32'(v0));
        if (v0) check({tag, " d0"}, 32'(p0_rdata), 32'(d0));
        check({tag, " v1"}, 32'(p1_rvalid), 32'(v1));
        if (v1) check({tag, " d1"}, 32'(p1_rdata), 32'(d1));
    endtask

    task automatic do_reset();
        p0_op = NOP; p1_op = NOP;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 stall in reset", 32'(stall), 32'd0);
        check("R1 mem strobes in reset", 32'({mem_we, mem_re}), 32'd0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 rvalid after reset", 32'({p0_rvalid, p1_rvalid}), 32'd0);
        check("R1 stall after reset", 32'(stall), 32'd0);
    endtask

    initial begin
        #(CLK_NS * 20000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();

        // R2 R3 R4 R5: vector table, no dribbling expected
        for (int i = 0; i < 8; i++) begin
            drive(VECS[i].op0, VECS[i].w0, VECS[i].k0, VECS[i].op1, VECS[i].w1, VECS[i].k1);
            expect_rd($sformatf("R2/R3/R4/R5 vec%0d", i), VECS[i].v0, VECS[i].d0,
                      VECS[i].v1, VECS[i].d1);
            check($sformatf("R5 vec%0d no stall", i), 32'(stall), 32'd0);
        end

        // R6 R10 R11: overflow of thread 0 half, push during stall dropped
        do_reset();
        for (int i = 0; i < 4; i++) begin
            drive(PSH, 16'hA000 + 16'(i), 0, NOP, 0, 0);
        end
        expect_spill("R6 overflow spill", 6'd0, 16'hA000);
        drive(PSH, 16'hA004, 0, POP, 0, 0);
        check("R10 rvalid after stall", 32'({p0_rvalid, p1_rvalid}), 32'd0);
        check("R10 stall released", 32'(stall), 32'd0);
        drive(POP, 0, 0, NOP, 0, 0);
        expect_rd("R10 push in stall ignored", 1'b1, 16'hA003, 1'b0, 0);
        drive(POP, 0, 0, NOP, 0, 0);
        expect_rd("R2 pop", 1'b1, 16'hA002, 1'b0, 0);
        expect_fill("R8 low fill t0", 6'd0);
        drive(NOP, 0, 0, NOP, 0, 0);
        check("R8 fill done", 32'(stall), 32'd0);
        drive(POP, 0, 0, NOP, 0, 0);
        expect_rd("R8 pop", 1'b1, 16'hA001, 1'b0, 0);
        check("R8 no refill", 32'(stall), 32'd0);
        drive(POP, 0, 0, NOP, 0, 0);
        expect_rd("R8 refilled word", 1'b1, 16'hA000, 1'b0, 0);

        // R7 R9 R11: shared occupancy spills, then empty-thread fills
        do_reset();
        drive(PSH, 16'hC000, 0, PSH, 16'hD000, 0);
        drive(PSH, 16'hC001, 0, PSH, 16'hD001, 0);
        check("R7 at high mark no stall", 32'(stall), 32'd0);
        drive(NOP, 0, 0, PSH, 16'hD002, 0);
        expect_spill("R7 spill larger t1", 6'd32, 16'hD000);
        drive(NOP, 0, 0, NOP, 0, 0);
        check("R7 spill stops", 32'(stall), 32'd0);
        drive(PSH, 16'hC002, 0, NOP, 0, 0);
        expect_spill("R7 spill larger t0", 6'd0, 16'hC000);
        drive(NOP, 0, 0, NOP, 0, 0);
        drive(NOP, 0, 0, PSH, 16'hD003, 0);
        expect_spill("R11 t1 second index", 6'd33, 16'hD001);
        drive(NOP, 0, 0, NOP, 0, 0);
        drive(PSH, 16'hC003, 0, PSH, 16'hD004, 0);
        expect_spill("R7 tie picks t0", 6'd1, 16'hC001);
        drive(NOP, 0, 0, NOP, 0, 0);
        expect_spill("R7 one word per cycle", 6'd34, 16'hD002);
        drive(NOP, 0, 0, NOP, 0, 0);
        check("R7 settled", 32'(stall), 32'd0);
        drive(POP, 0, 0, POP, 0, 0);
        expect_rd("R2 pop both", 1'b1, 16'hC003, 1'b1, 16'hD004);
        drive(POP, 0, 0, POP, 0, 0);
        expect_rd("R2 pop both 2", 1'b1, 16'hC002, 1'b1, 16'hD003);
        expect_fill("R9 empty t0 fill", 6'd1);
        drive(NOP, 0, 0, NOP, 0, 0);
        expect_fill("R9 empty t1 fill", 6'd34);
        drive(NOP, 0, 0, NOP, 0, 0);
        check("R9 fills done", 32'(stall), 32'd0);
        drive(POP, 0, 0, POP, 0, 0);
        expect_rd("R8 restored words", 1'b1, 16'hC001, 1'b1, 16'hD002);
        expect_fill("R11 fill t0 index0", 6'd0);
        drive(NOP, 0, 0, NOP, 0, 0);
        expect_fill("R11 fill t1 index1", 6'd33);
        drive(NOP, 0, 0, NOP, 0, 0);
        drive(POP, 0, 0, POP, 0, 0);
        expect_rd("R8 restored words 2", 1'b1, 16'hC000, 1'b1, 16'hD001);
        expect_fill("R9 t1 last fill", 6'd32);
        drive(NOP, 0, 0, NOP, 0, 0);
        check("R9 all filled", 32'(stall), 32'd0);
        drive(NOP, 0, 0, POP, 0, 0);
        expect_rd("R8 oldest back", 1'b0, 0, 1'b1, 16'hD000);
        drive(POP, 0, 0, POP, 0, 0);
        expect_rd("R4 both empty", 1'b0, 0, 1'b0, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule